// File: doc/BRIEF.md
# Predicated Micro-Operation Condition Gate

This block decides, for a predicated micro-operation, whether it should carry out its work. It takes a five-bit condition code and the current flag word and produces two registered bits one clock later. The pass bit says whether the selected condition holds. The error bit says that the selected condition belongs to a reserved string-operation group that is not supported.

The lower sixteen codes name base tests. A base test is one of three things: a constant, a read of a single flag, or a small OR or XOR combination of flags. Two of the base tests read a pair of emulation flags that sit above the architectural flags in the word. The upper sixteen codes are the complements of the base tests, taken in the same order. Four base codes and their four complements are reserved. Selecting any of them raises the error bit and forces pass high, which is the fallback for an unknown condition.

A scheduler places the block next to the flag register. The scheduler presents a code and the flags each cycle and reads the verdict on the following cycle.

Top module: `cond_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it, pass_o and err_o are both 0.
- R2: Both outputs change only at a rising clock edge, and they reflect the code and flag word sampled at that edge, which gives one cycle of latency.
- R3: Code 0 gives pass 1 and code 16 gives pass 0, whatever the flags are, with err 0 in both cases.
- R4: Single-flag codes give pass equal to one flag bit: code 1 reads bit 16 (emulation carry), code 2 reads bit 17 (emulation zero), code 8 reads bit 11 (overflow), code 9 reads bit 0 (carry), code 10 reads bit 6 (zero), code 12 reads bit 7 (sign) and code 13 reads bit 2 (parity).
- R5: Code 11 gives carry OR zero, code 14 gives sign XOR overflow, and code 15 gives (sign XOR overflow) OR zero.
- R6: Code 3 passes in every case except one: bit 17 (emulation zero) is 0 and bit 6 (zero) is 1.
- R7: For each supported base code c from 0 to 15, code c+16 gives the logical inverse of the pass that code c gives for the same flags.
- R8: Codes 4 to 7 and 20 to 23 give err 1 and pass 1, and the flags have no effect on them.
- R9: Flag word bits other than 0, 2, 6, 7, 11, 16 and 17 have no effect on pass.
- R10: Every code outside R8 gives err 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_i | input | 5 | Condition code; bit 4 selects the complement |
| flags_i | input | FLAG_W (32) | Current flag word |
| pass_o | output | 1 | Registered verdict for the selected condition |
| err_o | output | 1 | Registered flag for an unsupported condition |

## Verification
On a reserved code, two functions act in the same cycle: the complement bit tries to invert the base result, and the error path forces pass high. The bench selects reserved codes from both halves of the code space under all-zero and all-one flag words. It then judges that pass stays 1 and err rises, so no inversion shows through. A second collision is between the one-cycle latency and a new code. The bench changes from code 0 to code 16 and checks the old verdict before the clock edge and the new verdict after it.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;

    localparam int SEL_W  = 5;
    localparam int BASE_N = 1 << (SEL_W - 1);
    localparam int CODE_N = 1 << SEL_W;

    // Bit positions inside the flag word
    localparam int POS_CARRY     = 0;
    localparam int POS_PARITY    = 2;
    localparam int POS_ZERO      = 6;
    localparam int POS_SIGN      = 7;
    localparam int POS_OVF       = 11;
    localparam int POS_EMU_CARRY = 16;
    localparam int POS_EMU_ZERO  = 17;
    localparam int POS_TOP       = POS_EMU_ZERO;

    // Base test codes; the order is the encoding
    typedef enum logic [SEL_W-2:0] {
        TST_ALWAYS        = 4'd0,
        TST_EMU_CARRY     = 4'd1,
        TST_EMU_ZERO      = 4'd2,
        TST_ZERO_GUARD    = 4'd3,
        TST_STR_A         = 4'd4,
        TST_STR_B         = 4'd5,
        TST_STR_C         = 4'd6,
        TST_STR_D         = 4'd7,
        TST_OVF           = 4'd8,
        TST_CARRY         = 4'd9,
        TST_ZERO          = 4'd10,
        TST_CARRY_OR_ZERO = 4'd11,
        TST_SIGN          = 4'd12,
        TST_PARITY        = 4'd13,
        TST_SIGN_NE_OVF   = 4'd14,
        TST_LESS_EQ       = 4'd15
    } base_test_e;

    localparam int STR_FIRST = 4;
    localparam int STR_LAST  = 7;

    typedef struct packed {
        logic carry;
        logic parity;
        logic zero;
        logic sign;
        logic ovf;
        logic emu_carry;
        logic emu_zero;
    } flag_set_t;

    typedef struct packed {
        logic pass;
        logic err;
    } verdict_t;

endpackage

// File: rtl/cond_flag_pick.sv
module cond_flag_pick
    import cond_gate_pkg::*;
#(
    parameter int FLAG_W = 32
) (
    input  logic [FLAG_W-1:0] word_i,
    output flag_set_t         flags_o
);

    localparam int TOP_NEEDED = POS_TOP + 1;

    generate
        if (FLAG_W < TOP_NEEDED) begin : g_bad_width
            initial $error("flag word narrower than the highest used bit");
        end
    endgenerate

    always_comb begin
        flags_o.carry     = word_i[POS_CARRY];
        flags_o.parity    = word_i[POS_PARITY];
        flags_o.zero      = word_i[POS_ZERO];
        flags_o.sign      = word_i[POS_SIGN];
        flags_o.ovf       = word_i[POS_OVF];
        flags_o.emu_carry = word_i[POS_EMU_CARRY];
        flags_o.emu_zero  = word_i[POS_EMU_ZERO];
    end

endmodule

// File: rtl/cond_base_eval.sv
module cond_base_eval
    import cond_gate_pkg::*;
(
    input  flag_set_t         flags_i,
    output logic [BASE_N-1:0] res_o,
    output logic [BASE_N-1:0] unsup_o
);

    logic sign_ne_ovf;

    assign sign_ne_ovf = flags_i.sign ^ flags_i.ovf;

    always_comb begin
        res_o                    = '0;
        res_o[TST_ALWAYS]        = 1'b1;
        res_o[TST_EMU_CARRY]     = flags_i.emu_carry;
        res_o[TST_EMU_ZERO]      = flags_i.emu_zero;
        res_o[TST_ZERO_GUARD]    = ~(~flags_i.emu_zero & flags_i.zero);
        res_o[TST_OVF]           = flags_i.ovf;
        res_o[TST_CARRY]         = flags_i.carry;
        res_o[TST_ZERO]          = flags_i.zero;
        res_o[TST_CARRY_OR_ZERO] = flags_i.carry | flags_i.zero;
        res_o[TST_SIGN]          = flags_i.sign;
        res_o[TST_PARITY]        = flags_i.parity;
        res_o[TST_SIGN_NE_OVF]   = sign_ne_ovf;
        res_o[TST_LESS_EQ]       = sign_ne_ovf | flags_i.zero;
    end

    genvar g;
    generate
        for (g = 0; g < BASE_N; g++) begin : g_unsup
            if (g >= STR_FIRST && g <= STR_LAST) begin : g_rsv
                assign unsup_o[g] = 1'b1;
            end else begin : g_ok
                assign unsup_o[g] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/cond_gate.sv
module cond_gate
    import cond_gate_pkg::*;
#(
    parameter int FLAG_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              pass_o,
    output logic              err_o
);

    flag_set_t         flags;
    logic [BASE_N-1:0] base_res;
    logic [BASE_N-1:0] base_unsup;
    logic [CODE_N-1:0] full_res;
    logic [CODE_N-1:0] full_unsup;
    verdict_t          vd_d;
    verdict_t          vd_q;

    cond_flag_pick #(.FLAG_W(FLAG_W)) u_pick (
        .word_i  (flags_i),
        .flags_o (flags)
    );

    cond_base_eval u_base (
        .flags_i (flags),
        .res_o   (base_res),
        .unsup_o (base_unsup)
    );

    // Upper half of the code space mirrors the lower half inverted
    genvar g;
    generate
        for (g = 0; g < CODE_N; g++) begin : g_code
            if (g < BASE_N) begin : g_plain
                assign full_res[g]   = base_res[g];
                assign full_unsup[g] = base_unsup[g];
            end else begin : g_inv
                assign full_res[g]   = ~base_res[g-BASE_N];
                assign full_unsup[g] = base_unsup[g-BASE_N];
            end
        end
    endgenerate

    always_comb begin
        vd_d.err  = full_unsup[sel_i];
        vd_d.pass = full_unsup[sel_i] ? 1'b1 : full_res[sel_i];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vd_q <= '0;
        end else begin
            vd_q <= vd_d;
        end
    end

    assign pass_o = vd_q.pass;
    assign err_o  = vd_q.err;

endmodule

// File: rtl/cond_gate_chk.sv
module cond_gate_chk
    import cond_gate_pkg::*;
#(
    parameter int FLAG_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [SEL_W-1:0]  sel_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic              pass_o,
    input logic              err_o
);

    logic primed_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) primed_q <= 1'b0;
        else         primed_q <= 1'b1;
    end

    // R8 / R10: error bit tracks the reserved group of the previous code
    p_err_group_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed_q |-> (err_o == ($past(sel_i[3:2]) == 2'b01)));

    // R8: error always comes with pass high
    p_err_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> pass_o);

    p_always_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(sel_i) == 5'd0) |-> (pass_o && !err_o));

    p_never_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(sel_i) == 5'd16) |-> (!pass_o && !err_o));

    p_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(sel_i) == 5'd9) |-> (pass_o == $past(flags_i[POS_CARRY])));

    p_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(sel_i) == 5'd3) |->
        (pass_o == !(!$past(flags_i[POS_EMU_ZERO]) && $past(flags_i[POS_ZERO]))));

    // R1: first cycle after reset shows cleared outputs
    p_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !primed_q |-> (!pass_o && !err_o));

endmodule

bind cond_gate cond_gate_chk #(.FLAG_W(FLAG_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .flags_i (flags_i),
    .pass_o  (pass_o),
    .err_o   (err_o)
);

// File: tb/cond_gate_test.sv
`timescale 1ns/1ps
module cond_gate_test;

    localparam int FW = 32;
    localparam logic [FW-1:0] B_CF  = 32'h0000_0001;
    localparam logic [FW-1:0] B_PF  = 32'h0000_0004;
    localparam logic [FW-1:0] B_ZF  = 32'h0000_0040;
    localparam logic [FW-1:0] B_SF  = 32'h0000_0080;
    localparam logic [FW-1:0] B_OF  = 32'h0000_0800;
    localparam logic [FW-1:0] B_ECF = 32'h0001_0000;
    localparam logic [FW-1:0] B_EZF = 32'h0002_0000;
    localparam logic [FW-1:0] USED  = B_CF | B_PF | B_ZF | B_SF | B_OF | B_ECF | B_EZF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    sel = '0;
    logic [FW-1:0] flags = '0;
    logic          pass;
    logic          err;
    int            n_checks = 0;
    int            n_errors = 0;
    bit            finished = 1'b0;

    always #4 clk = ~clk;

    cond_gate #(.FLAG_W(FW)) uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .sel_i   (sel),
        .flags_i (flags),
        .pass_o  (pass),
        .err_o   (err)
    );

    task automatic check(input string req, input logic got_p, input logic got_e,
                         input logic exp_p, input logic exp_e);
        n_checks++;
        if (got_p !== exp_p || got_e !== exp_e) begin
            n_errors++;
            $display("FAIL %s: pass=%b err=%b expected pass=%b err=%b (sel=%0d flags=%h)",
                     req, got_p, got_e, exp_p, exp_e, sel, flags);
        end
    endtask

    task automatic apply(input logic [4:0] s, input logic [FW-1:0] f);
        @(negedge clk);
        sel   = s;
        flags = f;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_r1;
        rst_n = 1'b0;
        sel   = 5'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 held", pass, err, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        sel   = 5'd4;
        #1;
        check("R1 first cycle", pass, err, 1'b0, 1'b0);
    endtask

    task automatic t_latency_r2;
        apply(5'd0, '0);
        check("R2 code0", pass, err, 1'b1, 1'b0);
        @(negedge clk);
        sel = 5'd16;
        #1;
        check("R2 before edge", pass, err, 1'b1, 1'b0);
        @(posedge clk);
        #1;
        check("R2 after edge", pass, err, 1'b0, 1'b0);
    endtask

    task automatic t_const_r3;
        apply(5'd0, '1);
        check("R3 code0 ones", pass, err, 1'b1, 1'b0);
        apply(5'd16, '1);
        check("R3 code16 ones", pass, err, 1'b0, 1'b0);
        apply(5'd16, '0);
        check("R3 code16 zeros", pass, err, 1'b0, 1'b0);
    endtask

    task automatic t_single_r4;
        logic [4:0]    codes [7] = '{5'd1, 5'd2, 5'd8, 5'd9, 5'd10, 5'd12, 5'd13};
        logic [FW-1:0] bits  [7] = '{B_ECF, B_EZF, B_OF, B_CF, B_ZF, B_SF, B_PF};
        for (int i = 0; i < 7; i++) begin
            apply(codes[i], bits[i]);
            check("R4 own bit set", pass, err, 1'b1, 1'b0);
            apply(codes[i], USED & ~bits[i]);
            check("R4 others set", pass, err, 1'b0, 1'b0);
        end
    endtask

    task automatic t_combo_r5;
        apply(5'd11, B_CF);       check("R5 cf|zf c", pass, err, 1'b1, 1'b0);
        apply(5'd11, B_ZF);       check("R5 cf|zf z", pass, err, 1'b1, 1'b0);
        apply(5'd11, B_SF);       check("R5 cf|zf none", pass, err, 1'b0, 1'b0);
        apply(5'd14, B_SF);       check("R5 sf^of s", pass, err, 1'b1, 1'b0);
        apply(5'd14, B_SF | B_OF); check("R5 sf^of both", pass, err, 1'b0, 1'b0);
        apply(5'd15, B_SF | B_OF); check("R5 le eq", pass, err, 1'b0, 1'b0);
        apply(5'd15, B_SF | B_OF | B_ZF); check("R5 le zf", pass, err, 1'b1, 1'b0);
        apply(5'd15, B_OF);       check("R5 le of", pass, err, 1'b1, 1'b0);
    endtask

    task automatic t_guard_r6;
        apply(5'd3, B_ZF);         check("R6 ezf0 zf1", pass, err, 1'b0, 1'b0);
        apply(5'd3, B_ZF | B_EZF); check("R6 ezf1 zf1", pass, err, 1'b1, 1'b0);
        apply(5'd3, '0);           check("R6 ezf0 zf0", pass, err, 1'b1, 1'b0);
        apply(5'd3, B_EZF);        check("R6 ezf1 zf0", pass, err, 1'b1, 1'b0);
    endtask

    task automatic t_complement_r7;
        logic [FW-1:0] pats [4] = '{'0, USED, B_CF | B_SF | B_EZF, B_ZF | B_OF | B_PF | B_ECF};
        logic p_lo;
        for (int pi = 0; pi < 4; pi++) begin
            for (int c = 0; c < 16; c++) begin
                if (c < 4 || c > 7) begin
                    apply(5'(c), pats[pi]);
                    p_lo = pass;
                    apply(5'(c + 16), pats[pi]);
                    check("R7 complement", pass, err, ~p_lo, 1'b0);
                end
            end
        end
    endtask

    task automatic t_reserved_r8;
        logic [4:0] rs [8] = '{5'd4, 5'd5, 5'd6, 5'd7, 5'd20, 5'd21, 5'd22, 5'd23};
        for (int i = 0; i < 8; i++) begin
            apply(rs[i], '0);
            check("R8 reserved zeros", pass, err, 1'b1, 1'b1);
            apply(rs[i], '1);
            check("R8 reserved ones", pass, err, 1'b1, 1'b1);
        end
    endtask

    task automatic t_unused_r9;
        apply(5'd9, ~USED);         check("R9 carry noise", pass, err, 1'b0, 1'b0);
        apply(5'd25, ~USED);        check("R9 not carry noise", pass, err, 1'b1, 1'b0);
        apply(5'd15, ~USED);        check("R9 le noise", pass, err, 1'b0, 1'b0);
        apply(5'd3, ~USED | B_ZF);  check("R9 guard noise", pass, err, 1'b0, 1'b0);
    endtask

    task automatic t_err_clear_r10;
        for (int c = 0; c < 32; c++) begin
            if ((c % 16) < 4 || (c % 16) > 7) begin
                apply(5'(c), '1);
                n_checks++;
                if (err !== 1'b0) begin
                    n_errors++;
                    $display("FAIL R10: code %0d err=%b expected 0", c, err);
                end
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset_r1();
        t_latency_r2();
        t_const_r3();
        t_single_r4();
        t_combo_r5();
        t_guard_r6();
        t_complement_r7();
        t_reserved_r8();
        t_unused_r9();
        t_err_clear_r10();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule